// File: doc/BRIEF.md
# SCSI Selection and Reselection Detector

This block watches the synchronized control lines and data bus of a SCSI bus and recognises the moment another device selects or reselects this controller. It raises a one-cycle selection event once SEL has been active, BSY has been inactive and at least one data bit has overlapped the programmed ID mask, all three held for a programmable settle time counted in clock cycles. The I/O line sampled at that moment tells a reselection apart from a selection.

Alongside the event, the block captures two status flags for software. One marks the selection as improper when parity checking is enabled and a parity error is flagged. The other reports a bus that carried more than the permitted number of ID bits. Both flags, and the reselect indication, hold their values until the next detected event. After an event the detector stays quiet until SEL has gone inactive, so each selection produces exactly one pulse.

Top module: `scsi_sel_detect`

## Requirements
- R1: `sel_irq` pulses high for one cycle after `SETTLE_CYCLES` consecutive clock edges have sampled `sel_act`=1, `bsy_act`=0 and a non-zero `bus_data & sel_mask`; the pulse is visible right after the last of those edges.
- R2: A single bit of `bus_data` that is also set in `sel_mask` is enough for detection; data with no bit in common with the mask never produces an event.
- R3: At each event `resel` takes the value of `io_act` sampled on the detecting edge (1 = reselection, 0 = selection) and holds it until the next event.
- R4: While `sel_mask` is all zeros, `sel_irq` never pulses.
- R5: If any qualifying condition drops on a sampled edge, the settle count restarts, and a full `SETTLE_CYCLES` further edges are needed.
- R6: Only one `sel_irq` pulse is issued per selection; the detector arms again only after an edge samples `sel_act`=0.
- R7: At each event `sel_improper` is set to `par_chk_en & par_err` sampled on the detecting edge and held until the next event; it has no effect on whether the event occurs.
- R8: At each event `id_overflow` is set when more than `MAX_IDS` bits of `bus_data` are 1 on the detecting edge, otherwise cleared, and held until the next event.
- R9: While `rst_n` is low all outputs are 0 and the detector is armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sel_act | input | 1 | SEL line active (synchronized) |
| bsy_act | input | 1 | BSY line active (synchronized) |
| io_act | input | 1 | I/O line active (synchronized) |
| bus_data | input | ID_BITS | Data bus, one bit per device ID |
| sel_mask | input | ID_BITS | IDs this controller answers to |
| par_chk_en | input | 1 | Parity checking enabled |
| par_err | input | 1 | Parity error flag |
| sel_irq | output | 1 | One-cycle selection event |
| resel | output | 1 | Last event was a reselection |
| sel_improper | output | 1 | Last event had a parity error with checking on |
| id_overflow | output | 1 | Last event saw more than MAX_IDS ID bits |

## Verification
The bench builds the block with `SETTLE_CYCLES` = 4, `ID_BITS` = 8 and `MAX_IDS` = 2. The short settle window puts the exact edge of detection, a condition dropping one edge before completion, and the hold-off while SEL stays active all within a few cycles each. With two permitted IDs, buses carrying one, two and three ID bits sit on both sides of the overflow boundary.

// File: rtl/scsi_sel_detect.sv
module scsi_sel_detect #(
  parameter int unsigned SETTLE_CYCLES = 16,
  parameter int unsigned ID_BITS       = 8,
  parameter int unsigned MAX_IDS       = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sel_act,
  input  logic               bsy_act,
  input  logic               io_act,
  input  logic [ID_BITS-1:0] bus_data,
  input  logic [ID_BITS-1:0] sel_mask,
  input  logic               par_chk_en,
  input  logic               par_err,
  output logic               sel_irq,
  output logic               resel,
  output logic               sel_improper,
  output logic               id_overflow
);
  localparam int unsigned CNT_W = $clog2(SETTLE_CYCLES + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(SETTLE_CYCLES - 1);

  logic [CNT_W-1:0] cnt;
  logic             armed;
  logic             qual;
  logic             fire;
  logic             many;

  function automatic int unsigned popcnt(input logic [ID_BITS-1:0] v);
    int unsigned n = 0;
    for (int i = 0; i < int'(ID_BITS); i++) n += {31'd0, v[i]};
    return n;
  endfunction

  assign qual = sel_act && !bsy_act && (|(bus_data & sel_mask));
  assign fire = qual && armed && (cnt == LAST);
  assign many = popcnt(bus_data) > MAX_IDS;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt          <= '0;
      armed        <= 1'b1;
      sel_irq      <= 1'b0;
      resel        <= 1'b0;
      sel_improper <= 1'b0;
      id_overflow  <= 1'b0;
    end else begin
      sel_irq <= 1'b0;
      if (!sel_act) armed <= 1'b1;
      if (!qual || !armed) begin
        cnt <= '0;
      end else if (fire) begin
        cnt          <= '0;
        armed        <= 1'b0;
        sel_irq      <= 1'b1;
        resel        <= io_act;
        sel_improper <= par_chk_en && par_err;
        id_overflow  <= many;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  a_r1_qualified: assert property (@(posedge clk) disable iff (!rst_n)
    sel_irq |-> $past(sel_act && !bsy_act && (|(bus_data & sel_mask))));

  a_r3_resel_from_io: assert property (@(posedge clk) disable iff (!rst_n)
    sel_irq |-> (resel == $past(io_act)));

  a_r4_mask_zero_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(sel_mask) == '0) |-> !sel_irq);

  a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    sel_irq |=> !sel_irq);

  a_r7_improper_from_parity: assert property (@(posedge clk) disable iff (!rst_n)
    sel_irq |-> (sel_improper == $past(par_chk_en && par_err)));

  a_r5_settle_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LAST);
endmodule

// File: tb/scsi_sel_detect_tb.sv
module scsi_sel_detect_tb;
  localparam int unsigned ST = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sel_act = 1'b0, bsy_act = 1'b0, io_act = 1'b0;
  logic [7:0] bus_data = '0, sel_mask = '0;
  logic par_chk_en = 1'b0, par_err = 1'b0;
  logic sel_irq, resel, sel_improper, id_overflow;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  scsi_sel_detect #(.SETTLE_CYCLES(ST), .ID_BITS(8), .MAX_IDS(2)) u_dut (
    .clk(clk), .rst_n(rst_n), .sel_act(sel_act), .bsy_act(bsy_act),
    .io_act(io_act), .bus_data(bus_data), .sel_mask(sel_mask),
    .par_chk_en(par_chk_en), .par_err(par_err), .sel_irq(sel_irq),
    .resel(resel), .sel_improper(sel_improper), .id_overflow(id_overflow)
  );

  task automatic chk(input logic act, input logic exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle();
    sel_act = 0; bsy_act = 0; io_act = 0; bus_data = '0;
    par_chk_en = 0; par_err = 0;
    step(2);
  endtask

  task automatic drive(input logic [7:0] d, input logic io);
    bus_data = d; io_act = io; bsy_act = 0; sel_act = 1;
  endtask

  task automatic t_reset();
    rst_n = 0;
    step(3);
    chk(sel_irq, 1'b0, "R9 irq");
    chk(resel, 1'b0, "R9 resel");
    chk(sel_improper, 1'b0, "R9 improper");
    chk(id_overflow, 1'b0, "R9 overflow");
    rst_n = 1;
    step(1);
  endtask

  task automatic t_basic();
    sel_mask = 8'h40;
    drive(8'h41, 1'b0);
    step(ST - 1);
    chk(sel_irq, 1'b0, "R1 before settle");
    step(1);
    chk(sel_irq, 1'b1, "R1 at settle");
    chk(resel, 1'b0, "R3 selection");
    chk(id_overflow, 1'b0, "R8 two ids");
    step(1);
    chk(sel_irq, 1'b0, "R1 one cycle");
    idle();
  endtask

  task automatic t_no_overlap();
    sel_mask = 8'h02;
    drive(8'h81, 1'b0);
    for (int i = 0; i < 3 * ST; i++) begin
      step(1);
      chk(sel_irq, 1'b0, "R2 no overlap");
    end
    idle();
    drive(8'h03, 1'b0);
    step(ST);
    chk(sel_irq, 1'b1, "R2 single bit match");
    idle();
  endtask

  task automatic t_resel();
    sel_mask = 8'h10;
    drive(8'h14, 1'b1);
    step(ST);
    chk(sel_irq, 1'b1, "R3 resel event");
    chk(resel, 1'b1, "R3 resel flag");
    idle();
    chk(resel, 1'b1, "R3 resel held");
    drive(8'h10, 1'b0);
    step(ST);
    chk(resel, 1'b0, "R3 back to selection");
    idle();
  endtask

  task automatic t_mask_zero();
    sel_mask = 8'h00;
    drive(8'hFF, 1'b0);
    for (int i = 0; i < 3 * ST; i++) begin
      step(1);
      chk(sel_irq, 1'b0, "R4 mask zero");
    end
    idle();
  endtask

  task automatic t_restart();
    sel_mask = 8'h08;
    drive(8'h08, 1'b0);
    step(ST - 1);
    bsy_act = 1;
    step(1);
    chk(sel_irq, 1'b0, "R5 bsy drop");
    bsy_act = 0;
    step(ST - 1);
    chk(sel_irq, 1'b0, "R5 restarted count");
    step(1);
    chk(sel_irq, 1'b1, "R5 full window");
    idle();
    drive(8'h08, 1'b0);
    step(ST - 1);
    bus_data = 8'h01;
    step(1);
    bus_data = 8'h08;
    step(ST - 1);
    chk(sel_irq, 1'b0, "R5 data drop restart");
    step(1);
    chk(sel_irq, 1'b1, "R5 data drop full window");
    idle();
  endtask

  task automatic t_rearm();
    sel_mask = 8'h20;
    drive(8'h20, 1'b0);
    step(ST);
    chk(sel_irq, 1'b1, "R6 first event");
    for (int i = 0; i < 3 * ST; i++) begin
      step(1);
      chk(sel_irq, 1'b0, "R6 held off");
    end
    bsy_act = 1;
    step(1);
    bsy_act = 0;
    step(ST);
    chk(sel_irq, 1'b0, "R6 no rearm on bsy");
    sel_act = 0;
    step(1);
    sel_act = 1;
    step(ST);
    chk(sel_irq, 1'b1, "R6 rearmed");
    idle();
  endtask

  task automatic t_parity();
    sel_mask = 8'h04;
    par_chk_en = 1; par_err = 1;
    drive(8'h04, 1'b0);
    step(ST);
    chk(sel_irq, 1'b1, "R7 event despite parity");
    chk(sel_improper, 1'b1, "R7 improper set");
    idle();
    chk(sel_improper, 1'b1, "R7 improper held");
    par_chk_en = 0; par_err = 1;
    drive(8'h04, 1'b0);
    step(ST);
    chk(sel_improper, 1'b0, "R7 checking off");
    idle();
  endtask

  task automatic t_ids();
    sel_mask = 8'h01;
    drive(8'h07, 1'b0);
    step(ST);
    chk(sel_irq, 1'b1, "R8 event three ids");
    chk(id_overflow, 1'b1, "R8 three ids");
    idle();
    drive(8'h01, 1'b0);
    step(ST);
    chk(id_overflow, 1'b0, "R8 one id");
    idle();
  endtask

  initial begin
    step(1);
    t_reset();
    t_basic();
    t_no_overlap();
    t_resel();
    t_mask_zero();
    t_restart();
    t_rearm();
    t_parity();
    t_ids();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule